// File: doc/BRIEF.md
# Block Hysteresis Edge Marker

This block performs the double-threshold hysteresis step of an edge detector on one overlapped image block. It accepts a raster-ordered stream of square-block gradient magnitudes that have already been thinned by non-maximum suppression. With each pixel it also accepts a high and a low threshold, which come from a separate threshold unit. Each pixel is given one of three classes: strong, weak or none. A strong pixel is always an edge. A weak pixel is an edge only when at least one of its eight neighbours is strong. A pixel of class none is never an edge.

The neighbourhood is assembled from two line buffers that hold the class codes of the two previous rows, plus a three-column window. The block emits a one-bit edge decision only for pixels of the central part of the block. It drops a border of `BORDER` pixels on every side, where neighbouring blocks overlap. Each decision comes with a valid strobe and the row and column of the pixel in block coordinates. One pixel can be accepted per clock. Idle cycles stall the whole pipeline. After `BLK*BLK` accepted pixels the block starts over at row 0, column 0 for the next block.

Top module: `hyst_edge_marker`

## Requirements
- R1: A pixel whose magnitude is strictly greater than the high threshold present at its acceptance is strong, and it is reported as an edge (`edge_bit`=1).
- R2: A pixel whose magnitude is strictly greater than the low threshold and at most the high threshold is weak. It is reported as an edge exactly when at least one of its eight neighbours in the block is strong.
- R3: A pixel whose magnitude is at most the low threshold is never reported as an edge. This includes a magnitude equal to the low threshold. A magnitude equal to the high threshold counts as weak, not strong.
- R4: Decisions are issued only for pixels whose row and column both lie in `BORDER .. BLK-1-BORDER`. Border pixels produce no `edge_valid` pulse.
- R5: `edge_row` and `edge_col` carry the zero-based block position of the reported pixel, and decisions appear in raster order.
- R6: The decision for pixel (r,c) is presented, with `edge_valid` high for exactly one cycle, on the clock edge that accepts pixel (r+1,c+1).
- R7: A cycle with `pix_valid` low advances nothing. In the following cycle `edge_valid` is low and `edge_row`/`edge_col` keep their values.
- R8: After `BLK*BLK` accepted pixels, the position counters wrap and the next block starts at (0,0). Each block yields exactly `(BLK-2*BORDER)^2` decisions, and none of them depends on the previous block's pixels.
- R9: `edge_bit` is 0 whenever `edge_valid` is 0, including after reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous active-low reset |
| pix_valid | input | 1 | A pixel is presented this cycle |
| pix_mag | input | MAG_W | Suppressed gradient magnitude of the pixel |
| thr_high | input | MAG_W | High hysteresis threshold for the block |
| thr_low | input | MAG_W | Low hysteresis threshold for the block |
| edge_valid | output | 1 | One decision is presented this cycle |
| edge_bit | output | 1 | 1 when the reported pixel is an edge |
| edge_row | output | $clog2(BLK) | Block row of the reported pixel |
| edge_col | output | $clog2(BLK) | Block column of the reported pixel |

## Verification
The bench aims at the threshold equalities. A design that used greater-or-equal would make pixels at the high threshold strong and pixels at the low threshold weak, and would then emit extra edges. It covers isolated strong pixels surrounded by weak ones at every neighbour offset. A window that is misaligned by a row or a column would then drop or invent edges at specific offsets. Random idle cycles check that a stalled pipeline neither shifts its window nor pulses `edge_valid` twice. Several consecutive blocks with different thresholds check that the counters wrap cleanly and that stale line-buffer rows never leak into the first output row of a new block.

// File: rtl/hem_pkg.sv
package hem_pkg;

    // Two-bit class code kept per pixel in the line buffers.
    typedef logic [1:0] pix_cls_t;

    localparam pix_cls_t CLS_NONE   = 2'd0;
    localparam pix_cls_t CLS_WEAK   = 2'd1;
    localparam pix_cls_t CLS_STRONG = 2'd2;

    // Neighbourhood edge length (3x3 window).
    localparam int WIN = 3;

endpackage

// File: rtl/hem_classify.sv
module hem_classify
    import hem_pkg::*;
#(
    parameter int MAG_W = 8
) (
    input  logic [MAG_W-1:0] mag,
    input  logic [MAG_W-1:0] thr_hi,
    input  logic [MAG_W-1:0] thr_lo,
    output pix_cls_t         cls
);

    always_comb begin
        if (mag > thr_hi) begin
            cls = CLS_STRONG;
        end else if (mag > thr_lo) begin
            cls = CLS_WEAK;
        end else begin
            cls = CLS_NONE;
        end
    end

endmodule

// File: rtl/hem_line_buf.sv
module hem_line_buf
    import hem_pkg::*;
#(
    parameter int DEPTH  = 64,
    parameter int ADDR_W = $clog2(DEPTH)
) (
    input  logic              clk,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] addr,
    input  pix_cls_t          wr_data,
    output pix_cls_t          rd_data
);

    // One row of class codes; read returns the value stored one row ago.
    pix_cls_t mem_q [DEPTH];

    assign rd_data = mem_q[addr];

    always_ff @(posedge clk) begin
        if (wr_en) begin
            mem_q[addr] <= wr_data;
        end
    end

endmodule

// File: rtl/hem_neigh_eval.sv
module hem_neigh_eval
    import hem_pkg::*;
(
    // win[col][row]: col 0 newest, row 0 oldest; centre is win[1][1]
    input  logic [WIN-1:0][WIN-1:0][1:0] win,
    output logic                         is_edge
);

    logic strong_nb;

    always_comb begin
        strong_nb = 1'b0;
        for (int ci = 0; ci < WIN; ci++) begin
            for (int ri = 0; ri < WIN; ri++) begin
                if (!(ci == WIN / 2 && ri == WIN / 2) && win[ci][ri] == CLS_STRONG) begin
                    strong_nb = 1'b1;
                end
            end
        end
        is_edge = (win[WIN/2][WIN/2] == CLS_STRONG) ||
                  (win[WIN/2][WIN/2] == CLS_WEAK && strong_nb);
    end

endmodule

// File: rtl/hyst_edge_marker.sv
module hyst_edge_marker
    import hem_pkg::*;
#(
    parameter int BLK    = 64,
    parameter int MAG_W  = 8,
    parameter int BORDER = 1
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   pix_valid,
    input  logic [MAG_W-1:0]       pix_mag,
    input  logic [MAG_W-1:0]       thr_high,
    input  logic [MAG_W-1:0]       thr_low,
    output logic                   edge_valid,
    output logic                   edge_bit,
    output logic [$clog2(BLK)-1:0] edge_row,
    output logic [$clog2(BLK)-1:0] edge_col
);

    localparam int POS_W  = $clog2(BLK);
    localparam int NLINES = WIN - 1;
    localparam int LAST   = BLK - 1;
    localparam int CORE_LO = BORDER + 1;     // input row/col that centres on BORDER
    localparam int CORE_HI = BLK - BORDER;   // input row/col that centres on BLK-1-BORDER

    typedef struct packed {
        logic [POS_W-1:0]          col;
        logic [POS_W-1:0]          row;
        logic [WIN-1:0][1:0]       win_c1;   // column c-1 after shift
        logic [WIN-1:0][1:0]       win_c2;   // column c-2 after shift
        logic                      out_v;
        logic                      out_e;
        logic [POS_W-1:0]          out_r;
        logic [POS_W-1:0]          out_c;
    } state_t;

    state_t st_d, st_q;

    pix_cls_t                     cls_now;
    pix_cls_t                     chain [NLINES+1];
    logic [WIN-1:0][1:0]          new_col;
    logic [WIN-1:0][WIN-1:0][1:0] win;
    logic                         win_edge;
    logic                         in_core;

    hem_classify #(.MAG_W(MAG_W)) u_classify (
        .mag    (pix_mag),
        .thr_hi (thr_high),
        .thr_lo (thr_low),
        .cls    (cls_now)
    );

    assign chain[0] = cls_now;

    // Chain of row stores: store k returns the class from k+1 rows above.
    for (genvar k = 0; k < NLINES; k++) begin : g_rows
        hem_line_buf #(.DEPTH(BLK), .ADDR_W(POS_W)) u_row (
            .clk     (clk),
            .wr_en   (pix_valid),
            .addr    (st_q.col),
            .wr_data (chain[k]),
            .rd_data (chain[k+1])
        );
    end

    // Newest column: row index 0 oldest (r-2), WIN-1 current row.
    for (genvar k = 0; k < WIN; k++) begin : g_newcol
        assign new_col[k] = chain[WIN-1-k];
    end

    assign win[0] = new_col;
    assign win[1] = st_q.win_c1;
    assign win[2] = st_q.win_c2;

    hem_neigh_eval u_eval (
        .win     (win),
        .is_edge (win_edge)
    );

    always_comb begin
        in_core = (int'(st_q.row) >= CORE_LO) && (int'(st_q.row) <= CORE_HI) &&
                  (int'(st_q.col) >= CORE_LO) && (int'(st_q.col) <= CORE_HI);

        st_d       = st_q;
        st_d.out_v = 1'b0;
        st_d.out_e = 1'b0;
        if (pix_valid) begin
            st_d.win_c2 = st_q.win_c1;
            st_d.win_c1 = new_col;
            if (int'(st_q.col) == LAST) begin
                st_d.col = '0;
                st_d.row = (int'(st_q.row) == LAST) ? '0 : st_q.row + 1'b1;
            end else begin
                st_d.col = st_q.col + 1'b1;
            end
            st_d.out_v = in_core;
            st_d.out_e = in_core && win_edge;
            if (in_core) begin
                st_d.out_r = st_q.row - 1'b1;
                st_d.out_c = st_q.col - 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign edge_valid = st_q.out_v;
    assign edge_bit   = st_q.out_e;
    assign edge_row   = st_q.out_r;
    assign edge_col   = st_q.out_c;

    // Checks on the output stream.
    logic [POS_W-1:0] prev_col_q;
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            prev_col_q <= '0;
        end else if (edge_valid) begin
            prev_col_q <= edge_col;
        end
    end

    p_after_accept_r6: assert property (@(posedge clk) disable iff (!rst_n)
        edge_valid |-> $past(pix_valid))
        else $error("R6: decision without an accepted pixel");

    p_core_only_r4: assert property (@(posedge clk) disable iff (!rst_n)
        edge_valid |-> (int'(edge_row) >= BORDER && int'(edge_row) <= LAST - BORDER &&
                        int'(edge_col) >= BORDER && int'(edge_col) <= LAST - BORDER))
        else $error("R4: decision outside the central region");

    p_quiet_edge_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !edge_valid |-> !edge_bit)
        else $error("R9: edge bit set without valid");

    p_raster_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (edge_valid && int'(edge_col) != BORDER) |-> (edge_col == prev_col_q + 1'b1))
        else $error("R5: column order broken");

    p_stall_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !pix_valid |=> (!edge_valid && $stable(edge_row) && $stable(edge_col)))
        else $error("R7: outputs moved during a stall");

endmodule

// File: tb/hyst_edge_marker_bench.sv
module hyst_edge_marker_bench;

    localparam int CLK_PERIOD = 10;
    localparam int BLK    = 64;
    localparam int MAG_W  = 8;
    localparam int BORDER = 1;
    localparam int POS_W  = $clog2(BLK);
    localparam int NBLK   = 5;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             pix_valid = 1'b0;
    logic [MAG_W-1:0] pix_mag = '0;
    logic [MAG_W-1:0] thr_high = '0;
    logic [MAG_W-1:0] thr_low = '0;
    logic             edge_valid;
    logic             edge_bit;
    logic [POS_W-1:0] edge_row;
    logic [POS_W-1:0] edge_col;

    int errors = 0;
    int checks = 0;

    // Reference state: class per pixel of the current block (0 none, 1 weak, 2 strong).
    int cls_m [BLK][BLK];
    bit exp_v = 0;
    bit exp_e = 0;
    int exp_r = 0;
    int exp_c = 0;
    int exp_cls = 0;
    bit last_stall = 0;
    int out_count = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    hyst_edge_marker #(.BLK(BLK), .MAG_W(MAG_W), .BORDER(BORDER)) u_hyst_edge_marker (
        .clk(clk), .rst_n(rst_n), .pix_valid(pix_valid), .pix_mag(pix_mag),
        .thr_high(thr_high), .thr_low(thr_low), .edge_valid(edge_valid),
        .edge_bit(edge_bit), .edge_row(edge_row), .edge_col(edge_col)
    );

    task automatic summary_and_end();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    endtask

    task automatic fail(string req, string what, int act, int expv);
        errors++;
        $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, expv);
    endtask

    // Compare the outputs against the model (called at a falling edge).
    task automatic compare();
        checks++;
        if (edge_valid !== exp_v) fail(last_stall ? "R7" : "R4/R6", "edge_valid", int'(edge_valid), int'(exp_v));
        if (!edge_valid) begin
            checks++;
            if (edge_bit !== 1'b0) fail("R9", "edge_bit while idle", int'(edge_bit), 0);
        end
        if (exp_v && edge_valid) begin
            out_count++;
            checks++;
            if (edge_bit !== exp_e)
                fail(exp_cls == 2 ? "R1" : (exp_cls == 1 ? "R2" : "R3"), "edge_bit", int'(edge_bit), int'(exp_e));
            checks++;
            if (int'(edge_row) != exp_r || int'(edge_col) != exp_c)
                fail("R5", "position row*BLK+col", int'(edge_row) * BLK + int'(edge_col), exp_r * BLK + exp_c);
        end
    endtask

    function automatic int classify(int m, int hi, int lo);
        if (m > hi) return 2;
        if (m > lo) return 1;
        return 0;
    endfunction

    function automatic int pick_mag(int pat, int r, int c, int hi, int lo);
        int opts [6];
        case (pat)
            1: begin
                opts = '{lo, lo + 1, hi, hi + 1, 0, 255};
                return opts[$urandom_range(0, 5)];
            end
            2: begin
                if (r % 5 == 2 && c % 7 == 3) return 255;
                return ($urandom_range(0, 1) == 1) ? hi : lo;
            end
            3: return $urandom_range(lo + 1, hi);
            default: return $urandom_range(0, 255);
        endcase
    endfunction

    // One clock: check what the previous edge produced, then drive this cycle.
    task automatic cycle(bit v, int m, int hi, int lo, int r, int c);
        @(negedge clk);
        compare();
        pix_valid = v;
        pix_mag   = MAG_W'(m);
        thr_high  = MAG_W'(hi);
        thr_low   = MAG_W'(lo);
        last_stall = !v;
        exp_v = 0;
        exp_e = 0;
        if (v) begin
            cls_m[r][c] = classify(m, hi, lo);
            if (r >= BORDER + 1 && r <= BLK - BORDER && c >= BORDER + 1 && c <= BLK - BORDER) begin
                bit nb = 0;
                exp_v = 1;
                exp_r = r - 1;
                exp_c = c - 1;
                exp_cls = cls_m[exp_r][exp_c];
                for (int dr = -1; dr <= 1; dr++)
                    for (int dc = -1; dc <= 1; dc++)
                        if (!(dr == 0 && dc == 0) && cls_m[exp_r + dr][exp_c + dc] == 2) nb = 1;
                exp_e = (exp_cls == 2) || (exp_cls == 1 && nb);
            end
        end
    endtask

    initial begin : watchdog
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual=%0d expected=%0d", 200000, 0);
        summary_and_end();
    end

    initial begin : main
        int his [NBLK] = '{100, 120, 90, 200, 80};
        int los [NBLK] = '{40, 60, 30, 10, 80};
        int pats [NBLK] = '{0, 1, 2, 3, 0};
        repeat (3) @(posedge clk);
        @(negedge clk);
        checks++;
        if (edge_valid !== 1'b0 || edge_bit !== 1'b0) fail("R9", "reset outputs", int'({edge_valid, edge_bit}), 0);
        rst_n = 1'b1;
        for (int b = 0; b < NBLK; b++) begin
            out_count = 0;
            for (int r = 0; r < BLK; r++) begin
                for (int c = 0; c < BLK; c++) begin
                    // R7: blocks 2 and 4 insert random idle cycles
                    if ((b == 2 || b == 4) && $urandom_range(0, 3) == 0)
                        cycle(0, 0, his[b], los[b], r, c);
                    cycle(1, pick_mag(pats[b], r, c, his[b], los[b]), his[b], los[b], r, c);
                end
            end
            cycle(0, 0, his[b], los[b], 0, 0);
            // R8: exact decision count per block, also after counter wrap
            checks++;
            if (out_count != (BLK - 2 * BORDER) * (BLK - 2 * BORDER))
                fail("R8", "decisions in block", out_count, (BLK - 2 * BORDER) * (BLK - 2 * BORDER));
        end
        @(negedge clk);
        compare();
        summary_and_end();
    end

endmodule